// File: doc/BRIEF.md
# Ethernet Receive-Clock Link Speed Detector

This block works out the speed of an Ethernet link by timing the receive clock that the PHY drives, and it chooses between the byte-wide gigabit interface and the nibble-wide interface for 10/100 links. It needs no PHY management read. In the receive clock domain a free-running two-bit counter flips a toggle once every four receive clocks. The toggle crosses into the system clock domain through a synchronizer chain, and each change becomes a one-cycle pulse there. The system domain counts these pulses over a fixed window of system clock cycles.

When the window closes, the count is compared against three bands. Each band is centred on the receive clock rate of one link speed (2.5 MHz, 25 MHz or 125 MHz) and is plus or minus a margin wide. The band limits are computed at elaboration time as count limits, so no multiplier is needed at run time. The block reports a speed code, the interface select bit, a one-cycle valid or fail strobe and the frozen raw count. A start strobe begins a new measurement at any time.

The system clock must be at least 125 MHz and at least as fast as the receive clock. With the defaults (125 MHz system clock, window of 12,500,000 cycles) the window lasts 100 ms, and the estimated receive clock frequency is the count times 40.

Top module: `link_rate_sensor`

## Requirements
- R1: While reset is held and after it is released, mii_sel_o is 0, speed_o is 2, valid_o and fail_o are 0, and count_o is 0.
- R2: count_o reports the number of four-receive-clock periods seen during a window of WINDOW_CYCLES system cycles. This is f_rx*WINDOW_CYCLES/(4*SYS_HZ), and the reported value is within two of it.
- R3: A count inside the 2.5 MHz band sets speed_o to 0 and mii_sel_o to 1, with a valid_o strobe.
- R4: A count inside the 25 MHz band sets speed_o to 1 and mii_sel_o to 1, with a valid_o strobe.
- R5: A count inside the 125 MHz band sets speed_o to 2 and mii_sel_o to 0, with a valid_o strobe.
- R6: A count outside every band raises fail_o, and mii_sel_o and speed_o keep their previous values.
- R7: A band covers the counts from ceil((T-M)*W/(4*SYS_HZ)) up to floor((T+M)*W/(4*SYS_HZ)), where T is the band centre, M is MARGIN_HZ and W is WINDOW_CYCLES. Both limits count as inside the band. The bands are tested in the order 0, 1, 2, and the first band that matches wins.
- R8: valid_o and fail_o are never high together, and each stays high for only one cycle. The strobe appears exactly WINDOW_CYCLES+2 rising clock edges after the edge that samples start_o... start_i high.
- R9: count_o changes only in a cycle in which valid_o or fail_o is high.
- R10: A start_i pulse during a measurement abandons it and no strobe is given for it. The next strobe then comes WINDOW_CYCLES+2 edges after the new start.
- R11: A start_i pulse in the cycle that closes a window still delivers that window's result. It also begins a new measurement, whose strobe follows WINDOW_CYCLES+2 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset, system domain |
| rxclk_i | input | 1 | Receive clock from the PHY, the clock being measured |
| start_i | input | 1 | Begins or restarts a measurement, system domain |
| mii_sel_o | output | 1 | 1 selects the nibble interface (10/100), 0 selects the byte interface (1G) |
| speed_o | output | 2 | Speed code: 0 for 10 Mb/s, 1 for 100 Mb/s, 2 for 1 Gb/s |
| valid_o | output | 1 | One-cycle strobe when a speed has been classified |
| fail_o | output | 1 | One-cycle strobe when the count fits no band |
| count_o | output | CNT_W | Raw pulse count of the last completed window |

## Verification
The start strobe and the end of a window can fall in the same cycle. To provoke this, the bench raises start_i in exactly the cycle that closes a window, after counting edges from the previous start. It then requires two things: the strobe with the correct speed for the finished window must still appear, and a second strobe must follow exactly WINDOW_CYCLES+2 edges after that start. A restart in the middle of a window is judged by the absence of any strobe until a full window has passed after the later start. Band edges are checked count by count on a separate instance of the classifier.

// File: rtl/link_rate_pkg.sv
package link_rate_pkg;

  typedef enum logic [1:0] {
    SPD_10M  = 2'd0,
    SPD_100M = 2'd1,
    SPD_1G   = 2'd2
  } speed_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_MEASURE,
    ST_DECIDE
  } state_e;

  localparam int NUM_BANDS = 3;

  // Receive clock rate per band, in Hz, in priority order.
  function automatic longint unsigned band_centre(input int idx);
    case (idx)
      0:       return 64'd2_500_000;
      1:       return 64'd25_000_000;
      default: return 64'd125_000_000;
    endcase
  endfunction

  // Smallest count whose frequency estimate is not below centre - margin.
  function automatic longint unsigned band_low(input longint unsigned centre,
                                               input longint unsigned margin,
                                               input longint unsigned sys_hz,
                                               input longint unsigned win);
    longint unsigned den;
    den = 4 * sys_hz;
    if (margin >= centre) return 0;
    return ((centre - margin) * win + den - 1) / den;
  endfunction

  // Largest count whose frequency estimate is not above centre + margin.
  function automatic longint unsigned band_high(input longint unsigned centre,
                                                input longint unsigned margin,
                                                input longint unsigned sys_hz,
                                                input longint unsigned win);
    return ((centre + margin) * win) / (4 * sys_hz);
  endfunction

endpackage

// File: rtl/rx_quarter_toggle.sv
// Receive clock domain: flips a toggle once every four receive clocks.
module rx_quarter_toggle (
  input  logic rxclk_i,
  output logic tog_o
);
  logic [1:0] div_q = 2'd0;
  logic       tog_q = 1'b0;

  always_ff @(posedge rxclk_i) begin
    div_q <= div_q + 2'd1;
    if (div_q == 2'd3) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/toggle_sync.sv
// System domain: resynchronizes a toggle and turns each change into a pulse.
module toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tog_i,
  output logic pulse_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '0;
    else       chain_q <= {chain_q[DEPTH-2:0], tog_i};
  end

  assign pulse_o = chain_q[DEPTH-1] ^ chain_q[DEPTH-2];
endmodule

// File: rtl/rate_bands.sv
// Compares a window count against the three precomputed speed bands.
module rate_bands
  import link_rate_pkg::*;
#(
  parameter longint unsigned SYS_HZ        = 125_000_000,
  parameter longint unsigned WINDOW_CYCLES = 12_500_000,
  parameter longint unsigned MARGIN_HZ     = 1_000_000,
  parameter int              CNT_W         = 32
) (
  input  logic [CNT_W-1:0] count_i,
  output logic             hit_o,
  output speed_e           speed_o
);
  logic [NUM_BANDS-1:0] in_band;
  logic [63:0]          count_w;

  assign count_w = {{(64-CNT_W){1'b0}}, count_i};

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam logic [63:0] LO =
      band_low(band_centre(b), MARGIN_HZ, SYS_HZ, WINDOW_CYCLES);
    localparam logic [63:0] HI =
      band_high(band_centre(b), MARGIN_HZ, SYS_HZ, WINDOW_CYCLES);
    assign in_band[b] = (count_w >= LO) && (count_w <= HI);
  end

  assign hit_o = |in_band;

  always_comb begin
    if (in_band[0])      speed_o = SPD_10M;
    else if (in_band[1]) speed_o = SPD_100M;
    else                 speed_o = SPD_1G;
  end
endmodule

// File: rtl/link_rate_sensor.sv
module link_rate_sensor
  import link_rate_pkg::*;
#(
  parameter longint unsigned SYS_HZ        = 125_000_000,
  parameter longint unsigned WINDOW_CYCLES = 12_500_000,
  parameter longint unsigned MARGIN_HZ     = 1_000_000,
  parameter int              CNT_W         = 32,
  parameter int              SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             rxclk_i,
  input  logic             start_i,
  output logic             mii_sel_o,
  output logic [1:0]       speed_o,
  output logic             valid_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int            TW   = $clog2(WINDOW_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(WINDOW_CYCLES - 1);

  state_e           state_q;
  logic [TW-1:0]    timer_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rx_tog;
  logic             tick;
  logic             band_hit;
  speed_e           band_speed;

  rx_quarter_toggle u_div (
    .rxclk_i (rxclk_i),
    .tog_o   (rx_tog)
  );

  toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tog_i   (rx_tog),
    .pulse_o (tick)
  );

  rate_bands #(
    .SYS_HZ        (SYS_HZ),
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .MARGIN_HZ     (MARGIN_HZ),
    .CNT_W         (CNT_W)
  ) u_bands (
    .count_i (cnt_q),
    .hit_o   (band_hit),
    .speed_o (band_speed)
  );

  // Sequencer, window timer and pulse counter
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) state_q <= ST_CLEAR;
        end
        ST_CLEAR: begin
          cnt_q   <= '0;
          timer_q <= '0;
          if (!start_i) state_q <= ST_MEASURE;
        end
        ST_MEASURE: begin
          if (tick) cnt_q <= cnt_q + 1'b1;
          timer_q <= timer_q + 1'b1;
          if (start_i)              state_q <= ST_CLEAR;
          else if (timer_q == LAST) state_q <= ST_DECIDE;
        end
        default: begin
          state_q <= start_i ? ST_CLEAR : ST_IDLE;
        end
      endcase
    end
  end

  // Registered results
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mii_sel_o <= 1'b0;
      speed_o   <= SPD_1G;
      valid_o   <= 1'b0;
      fail_o    <= 1'b0;
      count_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      fail_o  <= 1'b0;
      if (state_q == ST_DECIDE) begin
        count_o <= cnt_q;
        if (band_hit) begin
          valid_o   <= 1'b1;
          speed_o   <= band_speed;
          mii_sel_o <= (band_speed != SPD_1G);
        end else begin
          fail_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/link_rate_sensor_chk.sv
module link_rate_sensor_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             mii_sel_o,
  input logic [1:0]       speed_o,
  input logic             valid_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] count_o
);
  // R1
  speed_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    speed_o != 2'd3);

  // R3
  mode_follows_speed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> (mii_sel_o == (speed_o != 2'd2)));

  // R6
  fail_keeps_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fail_o |-> ($stable(mii_sel_o) && $stable(speed_o)));

  // R8
  strobe_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(valid_o && fail_o));

  // R8
  valid_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  // R8
  fail_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fail_o |=> !fail_o);

  // R9
  count_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(valid_o || fail_o) |-> $stable(count_o));
endmodule

bind link_rate_sensor link_rate_sensor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .mii_sel_o (mii_sel_o),
  .speed_o   (speed_o),
  .valid_o   (valid_o),
  .fail_o    (fail_o),
  .count_o   (count_o)
);

// File: tb/link_rate_sensor_test.sv
`timescale 1ns/1ps
module link_rate_sensor_test;
  localparam real CLK_PERIOD = 5.0;          // 200 MHz system clock
  localparam longint unsigned SYS = 200_000_000;
  localparam longint unsigned WIN = 8000;    // 40 us window
  localparam int CW = 32;

  logic clk = 1'b0, rst = 1'b1, rx_clk = 1'b0, start = 1'b0;
  logic mii_sel, valid, fail;
  logic [1:0] speed;
  logic [CW-1:0] count;
  real rx_half = 20.0;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  logic [CW-1:0] probe = '0;
  logic          probe_hit;
  logic [1:0]    probe_speed;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(rx_half) rx_clk = ~rx_clk;

  link_rate_sensor #(
    .SYS_HZ(SYS), .WINDOW_CYCLES(WIN), .MARGIN_HZ(1_000_000), .CNT_W(CW), .SYNC_STAGES(2)
  ) uut (
    .clk_i(clk), .rst_i(rst), .rxclk_i(rx_clk), .start_i(start),
    .mii_sel_o(mii_sel), .speed_o(speed), .valid_o(valid), .fail_o(fail), .count_o(count)
  );

  // Stand-alone classifier for exact band-edge checks (R7)
  rate_bands #(.SYS_HZ(SYS), .WINDOW_CYCLES(WIN), .MARGIN_HZ(1_000_000), .CNT_W(CW)) bands (
    .count_i(probe), .hit_o(probe_hit), .speed_o(probe_speed)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // From the posedge that sampled start, count edges until a strobe is seen.
  task automatic wait_strobe(output int edges);
    edges = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (valid || fail || edges > int'(WIN) + 20) break;
      @(posedge clk);
      edges++;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
  endtask

  task automatic run_speed(input real half, input string req, input int exp_cnt,
                           input bit exp_ok, input int exp_spd, input bit exp_mii);
    int e;
    rx_half = half;
    repeat (20) @(posedge clk);
    pulse_start();
    wait_strobe(e);
    check(e == int'(WIN) + 2, {req, "/R8 strobe latency"}, e, int'(WIN) + 2);
    check(valid == exp_ok && fail == !exp_ok, {req, " strobe kind"}, {valid, fail}, {exp_ok, !exp_ok});
    check(speed == exp_spd, {req, " speed"}, speed, exp_spd);
    check(mii_sel == exp_mii, {req, " mii_sel"}, mii_sel, exp_mii);
    check(count >= exp_cnt - 2 && count <= exp_cnt + 2, "R2 count", count, exp_cnt);
    @(negedge clk);
    check(!valid && !fail, "R8 one-cycle strobe", {valid, fail}, 0);
  endtask

  task automatic test_reset();
    repeat (5) @(negedge clk);
    check(mii_sel == 0 && speed == 2 && !valid && !fail && count == 0, "R1 during reset",
          {mii_sel, speed, valid, fail}, 4);
    @(negedge clk) rst = 1'b0;
    repeat (3) @(negedge clk);
    check(mii_sel == 0 && speed == 2 && !valid && !fail && count == 0, "R1 after reset",
          {mii_sel, speed, valid, fail}, 4);
  endtask

  task automatic test_edges();
    int lo [3] = '{15, 240, 1240};
    int hi [3] = '{35, 260, 1260};
    for (int b = 0; b < 3; b++) begin
      probe = CW'(lo[b] - 1); #1;
      check(!probe_hit || probe_speed != b[1:0], "R7 below low edge", probe_hit, 0);
      probe = CW'(lo[b]); #1;
      check(probe_hit && probe_speed == b[1:0], "R7 low edge inside", probe_speed, b);
      probe = CW'(hi[b]); #1;
      check(probe_hit && probe_speed == b[1:0], "R7 high edge inside", probe_speed, b);
      probe = CW'(hi[b] + 1); #1;
      check(!probe_hit, "R7 above high edge", probe_hit, 0);
    end
  endtask

  task automatic test_restart();
    int e;
    bit seen = 1'b0;
    rx_half = 4.0;
    pulse_start();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (valid || fail) seen = 1'b1;
    end
    start = 1'b1;
    @(posedge clk);
    wait_strobe(e);
    check(!seen, "R10 no strobe from abandoned window", seen, 0);
    check(e == int'(WIN) + 2, "R10 latency after restart", e, int'(WIN) + 2);
    check(valid && speed == 2 && mii_sel == 0, "R10 result after restart", speed, 2);
  endtask

  task automatic test_start_at_close();
    int e;
    rx_half = 20.0;
    pulse_start();
    for (int i = 0; i < int'(WIN) + 1; i++) begin
      @(negedge clk);
      start = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    start = 1'b1;       // closing cycle of the window
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(valid && speed == 1 && mii_sel == 1, "R11 closing result kept", {valid, speed}, 5);
    @(posedge clk);
    e = 1;
    forever begin
      @(negedge clk);
      if (valid || fail || e > int'(WIN) + 20) break;
      @(posedge clk);
      e++;
    end
    check(e == int'(WIN) + 2, "R11 second window latency", e, int'(WIN) + 2);
    check(valid && speed == 1, "R11 second window result", speed, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    test_reset();
    test_edges();
    run_speed(200.0, "R3", 25, 1'b1, 0, 1'b1);
    run_speed(4.0, "R5", 1250, 1'b1, 2, 1'b0);
    run_speed(20.0, "R4", 250, 1'b1, 1, 1'b1);
    begin : fail_case
      logic [CW-1:0] held;
      run_speed(10.0, "R6", 500, 1'b0, 1, 1'b1);
      held = count;
      repeat (50) @(negedge clk);
      check(count == held, "R9 count frozen", count, held);
    end
    test_restart();
    test_start_at_close();
    finish_run();
  end
endmodule